// File: doc/BRIEF.md
# Fast Over-Range Detector

The block watches a set of parallel sample streams and raises a per-channel
flag whenever a sample's magnitude lies above a programmable fraction of full
scale. Samples are two's-complement words, one per channel per clock, framed
by a shared valid strobe. A 4-bit threshold code sets the trip level in
sixteenths of full scale. All channels use the same code, but each channel has
its own flag.

Each flag goes through a fixed-length delay line, so a downstream stage sees
it aligned with a known pipeline position. A change of the code is picked up
by the samples that arrive on the edge after it. Right after reset, the code
is 15.

Top module: `fast_ovr_det`

## Requirements
- R1: While reset is asserted, every bit of `ovr_o` is 0, and the delay line is cleared. After reset release, `ovr_o` stays 0 through the first 11 rising edges.
- R2: A sample captured on rising edge k sets `ovr_o` to its result after edge k+11 (12 register stages in total), and that value holds for exactly one cycle.
- R3: With full scale FS = 2^(DATA_W-1) (2048 by default), a valid sample trips when |x|·16 > code·FS. This is a strict comparison: |x| = code·FS/16 does not trip. With code 8, 1024 does not trip and 1025 does.
- R4: The magnitude of a negative sample is its absolute value. The most negative code (-2048) counts as 2048, so it trips for every code, and -1921 behaves like 1921.
- R5: Code 0 trips on every nonzero valid sample, including ±1. A zero sample never trips, whatever the code.
- R6: Channel c takes `data_i[c*DATA_W +: DATA_W]` and drives `ovr_o[c]`. All channels compare against the one shared code, and each channel's result is independent of the other channels' data.
- R7: The code present on edge k applies to the samples captured on edge k+1. Samples on the first edge after reset use code 15: 1920 does not trip and 1921 does.
- R8: A sample captured while `valid_i` is 0 produces a 0 result, whatever its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the samples of all channels on this edge |
| data_i | input | NUM_CH*DATA_W | Two's-complement samples; channel c in bits [c*DATA_W +: DATA_W] |
| thr_code_i | input | 4 | Shared threshold code in sixteenths of full scale |
| ovr_o | output | NUM_CH | Per-channel over-range flag, delayed by LATENCY edges |

## Verification
The checker checks the first pipeline stage on every cycle. It holds no result for invalid or zero samples, always trips on the most negative code, and trips on every nonzero sample under code 0. It also checks that the output stays quiet for the first 11 edges after reset.

The strict boundary at code·FS/16 under different codes is shown only by the bench's scenarios, which compare each cycle against a model. The same goes for the exact 12-edge alignment, the one-edge lag of a code update, the reset default of 15 and channel independence.

// File: rtl/fast_ovr_pkg.sv
package fast_ovr_pkg;
  localparam int unsigned THR_W = 4;
  typedef logic [THR_W-1:0] thr_code_t;
  localparam thr_code_t THR_CODE_RST = thr_code_t'(15);
endpackage

// File: rtl/fast_ovr_mag.sv
module fast_ovr_mag #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] mag_o
);
  // unsigned result: the most negative code maps to 2^(DATA_W-1)
  always_comb begin
    if (sample_i[DATA_W-1]) mag_o = ~sample_i + DATA_W'(1);
    else                    mag_o = sample_i;
  end
endmodule

// File: rtl/fast_ovr_cmp.sv
module fast_ovr_cmp
  import fast_ovr_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] mag_i,
  input  thr_code_t         code_i,
  input  logic              valid_i,
  output logic              hit_o
);
  localparam int unsigned PROD_W = DATA_W + THR_W;

  logic [PROD_W-1:0] lhs, rhs;

  always_comb begin
    lhs   = {mag_i, {THR_W{1'b0}}};
    rhs   = PROD_W'(code_i) << (DATA_W - 1);
    hit_o = valid_i && (lhs > rhs);
  end
endmodule

// File: rtl/fast_ovr_delay.sv
module fast_ovr_delay #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (DEPTH == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_line
    logic [WIDTH-1:0] stage_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
        stage_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
    end
    assign q_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/fast_ovr_det.sv
module fast_ovr_det
  import fast_ovr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned LATENCY = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [NUM_CH*DATA_W-1:0] data_i,
  input  logic [THR_W-1:0]         thr_code_i,
  output logic [NUM_CH-1:0]        ovr_o
);
  localparam int unsigned TAIL = (LATENCY > 0) ? LATENCY - 1 : 0;

  thr_code_t         thr_q;
  logic [NUM_CH-1:0] hit_d, hit_q;

  // code lags one edge so it applies to the next sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= THR_CODE_RST;
    else         thr_q <= thr_code_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] mag;
    fast_ovr_mag #(.DATA_W(DATA_W)) mag_i (
      .sample_i(data_i[c*DATA_W +: DATA_W]),
      .mag_o   (mag)
    );
    fast_ovr_cmp #(.DATA_W(DATA_W)) cmp_i (
      .mag_i  (mag),
      .code_i (thr_q),
      .valid_i(valid_i),
      .hit_o  (hit_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= '0;
    else         hit_q <= hit_d;
  end

  fast_ovr_delay #(.WIDTH(NUM_CH), .DEPTH(TAIL)) dly_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hit_q),
    .q_o   (ovr_o)
  );
endmodule

// File: rtl/fast_ovr_det_chk.sv
module fast_ovr_det_chk #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned LATENCY = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [NUM_CH*DATA_W-1:0] data_i,
  input logic [3:0]               thr_code_i,
  input logic [NUM_CH-1:0]        hit_q,
  input logic [NUM_CH-1:0]        ovr_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 2);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q < CNT_W'(LATENCY)) cnt_q <= cnt_q + CNT_W'(1);
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < CNT_W'(LATENCY)) |-> (ovr_o == '0));

  p_invalid_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (hit_q == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_most_neg_trips_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && data_i[c*DATA_W +: DATA_W] == MOST_NEG) |=> hit_q[c]);

    p_zero_sample_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_i[c*DATA_W +: DATA_W] == '0) |=> !hit_q[c]);

    p_code_zero_trips_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0 && valid_i && $past(thr_code_i) == 4'd0 &&
       data_i[c*DATA_W +: DATA_W] != '0) |=> hit_q[c]);
  end
endmodule

bind fast_ovr_det fast_ovr_det_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .LATENCY(LATENCY)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .data_i    (data_i),
  .thr_code_i(thr_code_i),
  .hit_q     (hit_q),
  .ovr_o     (ovr_o)
);

// File: tb/fast_ovr_det_tb.sv
module fast_ovr_det_tb_top;
  localparam int NCH = 2;
  localparam int DW  = 12;
  localparam int LAT = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [NCH*DW-1:0] data = '0;
  logic [3:0]      code = 4'd0;
  logic [NCH-1:0]  ovr;

  int tests = 0;
  int fails = 0;
  int edge_n = 0;
  int prev_code = 15;
  logic [NCH-1:0] exp_q [256];
  string          tag_q [256];

  always #4ns clk = ~clk;

  fast_ovr_det #(.NUM_CH(NCH), .DATA_W(DW), .LATENCY(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .thr_code_i(code), .ovr_o(ovr)
  );

  function automatic logic trip(input logic v, input logic [DW-1:0] d, input int c);
    int s = int'($signed(d));
    int m = (s < 0) ? -s : s;
    return v && (m * 16 > c * 2048);
  endfunction

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: ovr_o=%b expected %b", tag, edge_n, act, exp);
    end
  endtask

  // drive after a negedge; the next posedge is edge_n+1
  task automatic step(input logic v, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [3:0] c, input string tag);
    int idx = (edge_n + 1) % 256;
    valid = v;
    data  = {d1, d0};
    code  = c;
    exp_q[idx] = {trip(v, d1, prev_code), trip(v, d0, prev_code)};
    tag_q[idx] = tag;
    prev_code = int'(c);
    @(negedge clk);
    edge_n++;
    if (edge_n < LAT) check("R1 quiet after reset", ovr, '0);
    else              check(tag_q[(edge_n - LAT + 1) % 256], ovr, exp_q[(edge_n - LAT + 1) % 256]);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", ovr, '0);
    rst_n = 1'b1;
    // R7: first edge uses reset code 15; code 0 presented now applies next edge
    step(1'b1, 12'd1920, 12'd1921, 4'd0, "R7 default code 15");
    step(1'b1, 12'd1920, 12'd1921, 4'd15, "R7 code change lags one edge");
    // R4: negatives at code 15
    step(1'b1, -12'sd1920, -12'sd1921, 4'd15, "R4 negative boundary");
    step(1'b1, 12'h800, 12'd2047, 4'd0, "R4 most negative code");
    // R5: code 0
    step(1'b1, 12'd0, 12'd1, 4'd0, "R5 code 0 zero vs one");
    step(1'b1, -12'sd1, 12'd0, 4'd8, "R5 code 0 minus one");
    // R3: code 8 boundary, strict
    step(1'b1, 12'd1024, 12'd1025, 4'd8, "R3 strict boundary code 8");
    step(1'b1, -12'sd1024, -12'sd1025, 4'd3, "R3 negative boundary code 8");
    // R6: independent channels, shared code 3 -> limit 384
    step(1'b1, 12'd385, 12'd384, 4'd3, "R6 channel independence");
    step(1'b1, 12'd0, 12'd2000, 4'd3, "R6 channel independence");
    // R8: invalid samples
    step(1'b0, 12'h800, 12'd2047, 4'd0, "R8 invalid ignored");
    step(1'b0, 12'd5, -12'sd5, 4'd0, "R8 invalid ignored code 0");
    // R2: isolated pulse among quiet cycles
    step(1'b1, 12'd2047, 12'd0, 4'd15, "R2 isolated pulse");
    for (int i = 0; i < 13; i++) step(1'b0, 12'd0, 12'd0, 4'd15, "R2 pulse lasts one cycle");
    for (int i = 0; i < 600; i++) begin
      logic v = ($urandom % 5) != 0;
      logic [3:0] c = 4'($urandom % 16);
      logic [DW-1:0] d0 = DW'($urandom);
      logic [DW-1:0] d1 = DW'($urandom);
      step(v, d0, d1, c, "R3 random mix");
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 12'd0, 12'd0, 4'd15, "R2 flush");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule